// File: doc/BRIEF.md
# Vector Prefix Register-Extension Decoder

This block is one pipeline stage of an instruction decoder. It takes a 64-bit prefixed instruction as a 32-bit prefix word and a 32-bit suffix word. It checks whether the prefix is the vector-augmentation prefix. When it is, the block pulls a 24-bit remapped field out of the prefix and splits it into the predicate-mask, element-width, sub-vector-length, extra-tag and mode subfields.

The suffix decoder sits outside this block. It supplies an operand-profile code and the four 5-bit scalar register fields of the instruction. For each operand slot, the block uses the tag bits named by the profile to widen the 5-bit field into a 7-bit register number, and it marks that register as scalar or vector. It raises an illegal-instruction flag for reserved encodings. A prefix that does not match still passes through. In that case the decoded flag is low and every register keeps its plain scalar number, which matches the behaviour of an all-zero remapped field.

Results are held in one output register under a valid/ready handshake, one entry per accepted instruction.

Top module: `vpfx_decoder`

## Requirements
- R1: `decoded_o` is high exactly when `prefix_i[31:26]` is 6'b000001 and `prefix_i[24]` and `prefix_i[22]` are both 1.
- R2: On a match, the 24-bit remapped field is `{prefix_i[25], prefix_i[23], prefix_i[21:0]}`. Counting from its most significant bit, it holds the mask kind (1 bit), mask (3), destination element width (2), source element width (2), sub-vector length (2), extra (9) and mode (5). Each subfield appears on its own output.
- R3: A 3-bit tag t with t[2]=0 gives the scalar register t[1:0]*32+field. With t[2]=1 it gives the vector register field*4+t[1:0], and `reg_vec_o` is set.
- R4: A 2-bit tag maps as follows: 00 gives field, 01 gives 32+field, 10 gives vector field*4, and 11 gives vector field*4+2.
- R5: Profiles are numbered with the extra field's bit 8 as its most significant bit. Profile 0 uses 2-bit tags at extra[8:7], [6:5], [4:3] and [2:1] for slots dst, src1, src2 and aux. Profile 1 uses 3-bit tags at [8:6], [5:3] and [2:0] for dst, src1 and src2. Profile 2 uses 3-bit tags at [8:6] and [5:3] for dst and src1. Profile 3 uses 2-bit tags at [8:7], [6:5] and [4:3] for dst, src1 and src2. Profile 4 uses 2-bit tags at [8:7] for src1, [6:5] for dst and [4:3] for aux (a second destination). A slot that the profile does not use outputs register 0 with its valid and vector bits low. Slots are numbered 0 dst, 1 src1, 2 src2, 3 aux.
- R6: In profiles 2 and 3, `src_mask_o` is extra[2:0] and `src_mask_vld_o` is high; in other profiles both are 0. In profile 0, `alt_dst_o` is extra[0]; in other profiles it is 0.
- R7: `ew_bits_o` is 0 for destination element width 00. For codes 01, 10 and 11 it is 32, 16 and 8 (8<<(3-ew)).
- R8: On a match, `illegal_o` is set when `fp_single_i` is high and the destination element width is 10 or 11.
- R9: On a match, `illegal_o` is set when the profile code is 5, 6 or 7, or when the profile is 4 and extra[2:0] is non-zero.
- R10: If the prefix does not match, every subfield output is 0 and `illegal_o` is low. The registers in used slots come out as plain scalar numbers equal to the field. A matching prefix with an all-zero remapped field gives the same register outputs.
- R11: An input is accepted when `in_valid_i && in_ready_o`. Results come out in order. While `out_valid_o` is high and `out_ready_i` is low, the outputs hold and `in_ready_o` is low.
- R12: During and straight after reset, `out_valid_o` is low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Stage can accept |
| prefix_i | input | 32 | First instruction word |
| suffix_i | input | 32 | Second instruction word |
| profile_i | input | 3 | Operand profile code from the suffix decoder |
| fp_single_i | input | 1 | Suffix is a single-precision FP operation |
| field_i | input | 4x5 | Scalar register fields, slots dst/src1/src2/aux |
| out_valid_o | output | 1 | Result held |
| out_ready_i | input | 1 | Consumer takes result |
| decoded_o | output | 1 | Vector prefix recognised |
| illegal_o | output | 1 | Reserved encoding trap |
| suffix_o | output | 32 | Suffix word passed through |
| mask_kind_o | output | 1 | Predicate source kind |
| mask_o | output | 3 | Predicate mask select |
| ew_dst_o | output | 2 | Destination element-width code |
| ew_src_o | output | 2 | Source element-width code |
| ew_bits_o | output | 6 | Destination element width in bits, 0 for default |
| subvl_o | output | 2 | Sub-vector length code |
| mode_o | output | 5 | Mode subfield |
| src_mask_o | output | 3 | Source predicate mask (twin profiles) |
| src_mask_vld_o | output | 1 | Source mask present |
| alt_dst_o | output | 1 | Implicit second destination select |
| reg_o | output | 4x7 | Widened register numbers per slot |
| reg_vec_o | output | 4 | Slot is a vector register |
| reg_vld_o | output | 4 | Slot is used by the profile |

## Verification
The bench sweeps every 3-bit and 2-bit tag value against all 32 field values. This exposes a swapped vector/scalar placement, and it exposes the 2-bit vector code that must reach offset 2 rather than 1. Each operand profile is driven with distinct tags, which catches a tag read from the wrong bits of the extra field or a slot left valid when the profile does not use it. Illegal cases cover the f16/bf16 widths on single-precision operations, the reserved profile codes and stray reserved bits in profile 4. Non-matching prefixes with one marker bit cleared must not decode, trap or leak subfields. Random backpressure shows whether a result is dropped or changes while it is held.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;
  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned EXTRA_W   = 9;
  localparam int unsigned RM_W      = 24;

  typedef enum logic [2:0] {
    PROF_1P_4OP  = 3'd0,
    PROF_1P_3OP  = 3'd1,
    PROF_2P_1S1D = 3'd2,
    PROF_2P_2S1D = 3'd3,
    PROF_2P_1S2D = 3'd4
  } prof_e;

  typedef struct packed {
    logic             vec;
    logic [SEL_W-1:0] sel;
  } tag_t;

  function automatic tag_t tag_from3(input logic [2:0] t);
    tag_t r;
    r.vec = t[2];
    r.sel = t[1:0];
    return r;
  endfunction

  // 2-bit tag: scalar banks 0/1, vector offsets 0/2
  function automatic tag_t tag_from2(input logic [1:0] t);
    tag_t r;
    r.vec = t[1];
    r.sel = t[1] ? {t[0], 1'b0} : {1'b0, t[0]};
    return r;
  endfunction
endpackage

// File: rtl/vpfx_prefix_split.sv
module vpfx_prefix_split
  import vpfx_pkg::*;
#(
  parameter int unsigned INSN_W = 32
) (
  input  logic [INSN_W-1:0]  prefix_i,
  output logic               hit_o,
  output logic               mask_kind_o,
  output logic [2:0]         mask_o,
  output logic [1:0]         ew_dst_o,
  output logic [1:0]         ew_src_o,
  output logic [1:0]         subvl_o,
  output logic [EXTRA_W-1:0] extra_o,
  output logic [4:0]         mode_o
);
  localparam int unsigned OPC_W   = 6;
  localparam logic [OPC_W-1:0] OPC_VAL = 6'b000001;
  localparam int unsigned MARK_A  = INSN_W - 8;   // MSB0 bit 7
  localparam int unsigned MARK_B  = INSN_W - 10;  // MSB0 bit 9
  localparam int unsigned RM0_POS = INSN_W - 7;   // MSB0 bit 6
  localparam int unsigned RM1_POS = INSN_W - 9;   // MSB0 bit 8
  localparam int unsigned LOW_W   = RM_W - 2;

  logic [RM_W-1:0] rm;

  assign hit_o = (prefix_i[INSN_W-1 -: OPC_W] == OPC_VAL) &&
                 prefix_i[MARK_A] && prefix_i[MARK_B];

  assign rm = hit_o ? {prefix_i[RM0_POS], prefix_i[RM1_POS], prefix_i[LOW_W-1:0]}
                    : '0;

  assign mask_kind_o = rm[23];
  assign mask_o      = rm[22:20];
  assign ew_dst_o    = rm[19:18];
  assign ew_src_o    = rm[17:16];
  assign subvl_o     = rm[15:14];
  assign extra_o     = rm[13:5];
  assign mode_o      = rm[4:0];
endmodule

// File: rtl/vpfx_profile_map.sv
module vpfx_profile_map
  import vpfx_pkg::*;
(
  input  logic [2:0]                 profile_i,
  input  logic [EXTRA_W-1:0]         extra_i,
  output tag_t [NUM_SLOTS-1:0]       tag_o,
  output logic [NUM_SLOTS-1:0]       slot_vld_o,
  output logic [2:0]                 src_mask_o,
  output logic                       src_mask_vld_o,
  output logic                       alt_dst_o,
  output logic                       bad_layout_o
);
  localparam int unsigned S_DST = 0;
  localparam int unsigned S_SR1 = 1;
  localparam int unsigned S_SR2 = 2;
  localparam int unsigned S_AUX = 3;

  always_comb begin
    tag_o          = '0;
    slot_vld_o     = '0;
    src_mask_o     = '0;
    src_mask_vld_o = 1'b0;
    alt_dst_o      = 1'b0;
    bad_layout_o   = 1'b0;
    unique case (profile_i)
      PROF_1P_4OP: begin
        tag_o[S_DST] = tag_from2(extra_i[8:7]);
        tag_o[S_SR1] = tag_from2(extra_i[6:5]);
        tag_o[S_SR2] = tag_from2(extra_i[4:3]);
        tag_o[S_AUX] = tag_from2(extra_i[2:1]);
        slot_vld_o   = 4'b1111;
        alt_dst_o    = extra_i[0];
      end
      PROF_1P_3OP: begin
        tag_o[S_DST] = tag_from3(extra_i[8:6]);
        tag_o[S_SR1] = tag_from3(extra_i[5:3]);
        tag_o[S_SR2] = tag_from3(extra_i[2:0]);
        slot_vld_o   = 4'b0111;
      end
      PROF_2P_1S1D: begin
        tag_o[S_DST]   = tag_from3(extra_i[8:6]);
        tag_o[S_SR1]   = tag_from3(extra_i[5:3]);
        slot_vld_o     = 4'b0011;
        src_mask_o     = extra_i[2:0];
        src_mask_vld_o = 1'b1;
      end
      PROF_2P_2S1D: begin
        tag_o[S_DST]   = tag_from2(extra_i[8:7]);
        tag_o[S_SR1]   = tag_from2(extra_i[6:5]);
        tag_o[S_SR2]   = tag_from2(extra_i[4:3]);
        slot_vld_o     = 4'b0111;
        src_mask_o     = extra_i[2:0];
        src_mask_vld_o = 1'b1;
      end
      PROF_2P_1S2D: begin
        tag_o[S_SR1] = tag_from2(extra_i[8:7]);
        tag_o[S_DST] = tag_from2(extra_i[6:5]);
        tag_o[S_AUX] = tag_from2(extra_i[4:3]);
        slot_vld_o   = 4'b1011;
        bad_layout_o = |extra_i[2:0];
      end
      default: bad_layout_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/vpfx_reg_extend.sv
module vpfx_reg_extend
  import vpfx_pkg::*;
#(
  parameter int unsigned FIELD_W = 5,
  parameter int unsigned REG_W   = FIELD_W + SEL_W
) (
  input  logic               vld_i,
  input  tag_t               tag_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [REG_W-1:0]   reg_o,
  output logic               vec_o
);
  always_comb begin
    if (!vld_i) begin
      reg_o = '0;
      vec_o = 1'b0;
    end else if (tag_i.vec) begin
      reg_o = {field_i, tag_i.sel};   // stride-4 start points
      vec_o = 1'b1;
    end else begin
      reg_o = {tag_i.sel, field_i};   // bank select
      vec_o = 1'b0;
    end
  end
endmodule

// File: rtl/vpfx_decoder.sv
module vpfx_decoder
  import vpfx_pkg::*;
#(
  parameter int unsigned INSN_W  = 32,
  parameter int unsigned FIELD_W = 5,
  parameter int unsigned REG_W   = FIELD_W + SEL_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              in_valid_i,
  output logic                              in_ready_o,
  input  logic [INSN_W-1:0]                 prefix_i,
  input  logic [INSN_W-1:0]                 suffix_i,
  input  logic [2:0]                        profile_i,
  input  logic                              fp_single_i,
  input  logic [NUM_SLOTS-1:0][FIELD_W-1:0] field_i,
  output logic                              out_valid_o,
  input  logic                              out_ready_i,
  output logic                              decoded_o,
  output logic                              illegal_o,
  output logic [INSN_W-1:0]                 suffix_o,
  output logic                              mask_kind_o,
  output logic [2:0]                        mask_o,
  output logic [1:0]                        ew_dst_o,
  output logic [1:0]                        ew_src_o,
  output logic [5:0]                        ew_bits_o,
  output logic [1:0]                        subvl_o,
  output logic [4:0]                        mode_o,
  output logic [2:0]                        src_mask_o,
  output logic                              src_mask_vld_o,
  output logic                              alt_dst_o,
  output logic [NUM_SLOTS-1:0][REG_W-1:0]   reg_o,
  output logic [NUM_SLOTS-1:0]              reg_vec_o,
  output logic [NUM_SLOTS-1:0]              reg_vld_o
);
  typedef struct packed {
    logic                            dec;
    logic                            ill;
    logic [INSN_W-1:0]               sfx;
    logic                            mk;
    logic [2:0]                      mask;
    logic [1:0]                      ewd;
    logic [1:0]                      ews;
    logic [5:0]                      ewb;
    logic [1:0]                      svl;
    logic [4:0]                      mode;
    logic [2:0]                      sm;
    logic                            smv;
    logic                            alt;
    logic [NUM_SLOTS-1:0][REG_W-1:0] rg;
    logic [NUM_SLOTS-1:0]            vec;
    logic [NUM_SLOTS-1:0]            vld;
  } res_t;

  logic                 hit;
  logic [EXTRA_W-1:0]   extra;
  tag_t [NUM_SLOTS-1:0] tags;
  logic                 bad_layout;
  res_t                 d, q;
  logic                 vld_q;

  vpfx_prefix_split #(.INSN_W(INSN_W)) u_split (
    .prefix_i    (prefix_i),
    .hit_o       (hit),
    .mask_kind_o (d.mk),
    .mask_o      (d.mask),
    .ew_dst_o    (d.ewd),
    .ew_src_o    (d.ews),
    .subvl_o     (d.svl),
    .extra_o     (extra),
    .mode_o      (d.mode)
  );

  vpfx_profile_map u_map (
    .profile_i      (profile_i),
    .extra_i        (extra),
    .tag_o          (tags),
    .slot_vld_o     (d.vld),
    .src_mask_o     (d.sm),
    .src_mask_vld_o (d.smv),
    .alt_dst_o      (d.alt),
    .bad_layout_o   (bad_layout)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    vpfx_reg_extend #(.FIELD_W(FIELD_W), .REG_W(REG_W)) u_ext (
      .vld_i   (d.vld[s]),
      .tag_i   (tags[s]),
      .field_i (field_i[s]),
      .reg_o   (d.rg[s]),
      .vec_o   (d.vec[s])
    );
  end

  always_comb begin
    unique case (d.ewd)
      2'b00:   d.ewb = 6'd0;
      2'b01:   d.ewb = 6'd32;
      2'b10:   d.ewb = 6'd16;
      default: d.ewb = 6'd8;
    endcase
  end

  assign d.dec = hit;
  assign d.sfx = suffix_i;
  // f16/bf16 widths on single-precision ops are reserved
  assign d.ill = hit && (bad_layout || (fp_single_i && d.ewd[1]));

  assign in_ready_o = !vld_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      q     <= '0;
    end else begin
      if (in_ready_o) vld_q <= in_valid_i;
      if (in_valid_i && in_ready_o) q <= d;
    end
  end

  assign out_valid_o    = vld_q;
  assign decoded_o      = q.dec;
  assign illegal_o      = q.ill;
  assign suffix_o       = q.sfx;
  assign mask_kind_o    = q.mk;
  assign mask_o         = q.mask;
  assign ew_dst_o       = q.ewd;
  assign ew_src_o       = q.ews;
  assign ew_bits_o      = q.ewb;
  assign subvl_o        = q.svl;
  assign mode_o         = q.mode;
  assign src_mask_o     = q.sm;
  assign src_mask_vld_o = q.smv;
  assign alt_dst_o      = q.alt;
  assign reg_o          = q.rg;
  assign reg_vec_o      = q.vec;
  assign reg_vld_o      = q.vld;
endmodule

// File: rtl/vpfx_decoder_chk.sv
module vpfx_decoder_chk #(
  parameter int unsigned NSL   = 4,
  parameter int unsigned REG_W = 7
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        in_ready_o,
  input logic                        out_valid_o,
  input logic                        out_ready_i,
  input logic                        decoded_o,
  input logic                        illegal_o,
  input logic [2:0]                  mask_o,
  input logic [1:0]                  ew_dst_o,
  input logic [5:0]                  ew_bits_o,
  input logic [4:0]                  mode_o,
  input logic [NSL-1:0][REG_W-1:0]   reg_o,
  input logic [NSL-1:0]              reg_vec_o,
  input logic [NSL-1:0]              reg_vld_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r12: assert (!out_valid_o && in_ready_o);
    end
  end

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(reg_o) &&
      $stable(decoded_o) && $stable(illegal_o) && $stable(mode_o));

  p_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  p_trap_needs_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && illegal_o |-> decoded_o);

  p_nohit_plain_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !decoded_o |-> reg_vec_o == '0 && mask_o == '0 && mode_o == '0);

  p_width_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && ew_dst_o != 2'b00 |-> $countones(ew_bits_o) == 1);

  for (genvar s = 0; s < NSL; s++) begin : g_unused
    p_unused_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && !reg_vld_o[s] |-> reg_o[s] == '0 && !reg_vec_o[s]);
  end
endmodule

bind vpfx_decoder vpfx_decoder_chk #(.NSL(vpfx_pkg::NUM_SLOTS), .REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .decoded_o   (decoded_o),
  .illegal_o   (illegal_o),
  .mask_o      (mask_o),
  .ew_dst_o    (ew_dst_o),
  .ew_bits_o   (ew_bits_o),
  .mode_o      (mode_o),
  .reg_o       (reg_o),
  .reg_vec_o   (reg_vec_o),
  .reg_vld_o   (reg_vld_o)
);

// File: tb/vpfx_decoder_tb_top.sv
module vpfx_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic            dec, ill, mk, smv, alt;
    logic [31:0]     sfx;
    logic [2:0]      mask, sm;
    logic [1:0]      ewd, ews, svl;
    logic [5:0]      ewb;
    logic [4:0]      mode;
    logic [3:0][6:0] rg;
    logic [3:0]      vec, vld;
    string           rq;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, fp_single = 1'b0;
  logic [31:0] prefix = '0, suffix = '0;
  logic [2:0]  profile = '0;
  logic [3:0][4:0] field = '0;
  logic in_ready, out_valid, decoded, illegal, mask_kind, src_mask_vld, alt_dst;
  logic [31:0] suffix_q;
  logic [2:0]  mask, src_mask;
  logic [1:0]  ew_dst, ew_src, subvl;
  logic [5:0]  ew_bits;
  logic [4:0]  mode;
  logic [3:0][6:0] regs;
  logic [3:0]  reg_vec, reg_vld;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t sb[$];
  logic [7:0] lfsr = 8'h5a;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpfx_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .prefix_i(prefix), .suffix_i(suffix), .profile_i(profile), .fp_single_i(fp_single),
    .field_i(field), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .decoded_o(decoded), .illegal_o(illegal), .suffix_o(suffix_q),
    .mask_kind_o(mask_kind), .mask_o(mask), .ew_dst_o(ew_dst), .ew_src_o(ew_src),
    .ew_bits_o(ew_bits), .subvl_o(subvl), .mode_o(mode), .src_mask_o(src_mask),
    .src_mask_vld_o(src_mask_vld), .alt_dst_o(alt_dst), .reg_o(regs),
    .reg_vec_o(reg_vec), .reg_vld_o(reg_vld)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_prefix(input logic mk, input logic [2:0] m,
      input logic [1:0] ewd, input logic [1:0] ews, input logic [1:0] svl,
      input logic [8:0] ex, input logic [4:0] md);
    logic [23:0] rm;
    rm = {mk, m, ewd, ews, svl, ex, md};
    return {6'b000001, rm[23], 1'b1, rm[22], 1'b1, rm[21:0]};
  endfunction

  // returns {vec, reg}
  function automatic logic [7:0] ref3(input logic [2:0] t, input logic [4:0] f);
    if (t[2]) return {1'b1, 7'(7'(f) * 7'd4 + 7'(t[1:0]))};
    return {1'b0, 7'(7'(t[1:0]) * 7'd32 + 7'(f))};
  endfunction

  function automatic logic [7:0] ref2(input logic [1:0] t, input logic [4:0] f);
    case (t)
      2'd0:    return {1'b0, 7'(f)};
      2'd1:    return {1'b0, 7'(7'd32 + 7'(f))};
      2'd2:    return {1'b1, 7'(7'(f) * 7'd4)};
      default: return {1'b1, 7'(7'(f) * 7'd4 + 7'd2)};
    endcase
  endfunction

  task automatic send(input logic [31:0] p, input logic [31:0] s, input logic [2:0] pr,
                      input logic fp, input logic [3:0][4:0] f, input string rq);
    exp_t e;
    logic [8:0] x;
    logic [7:0] r [4];
    e.dec = (p[31:26] == 6'b000001) && p[24] && p[22];
    e.mk = e.dec ? p[25] : 1'b0;
    e.mask = e.dec ? {p[23], p[21:20]} : 3'd0;
    e.ewd = e.dec ? p[19:18] : 2'd0;
    e.ews = e.dec ? p[17:16] : 2'd0;
    e.svl = e.dec ? p[15:14] : 2'd0;
    x = e.dec ? p[13:5] : 9'd0;
    e.mode = e.dec ? p[4:0] : 5'd0;
    e.sfx = s;
    e.ewb = (e.ewd == 0) ? 6'd0 : (e.ewd == 1) ? 6'd32 : (e.ewd == 2) ? 6'd16 : 6'd8;
    e.sm = '0; e.smv = 0; e.alt = 0; e.vld = '0;
    for (int k = 0; k < 4; k++) r[k] = 8'd0;
    e.ill = e.dec && fp && e.ewd[1];
    case (pr)
      3'd0: begin
        r[0] = ref2(x[8:7], f[0]); r[1] = ref2(x[6:5], f[1]);
        r[2] = ref2(x[4:3], f[2]); r[3] = ref2(x[2:1], f[3]);
        e.vld = 4'b1111; e.alt = x[0];
      end
      3'd1: begin
        r[0] = ref3(x[8:6], f[0]); r[1] = ref3(x[5:3], f[1]); r[2] = ref3(x[2:0], f[2]);
        e.vld = 4'b0111;
      end
      3'd2: begin
        r[0] = ref3(x[8:6], f[0]); r[1] = ref3(x[5:3], f[1]);
        e.vld = 4'b0011; e.sm = x[2:0]; e.smv = 1;
      end
      3'd3: begin
        r[0] = ref2(x[8:7], f[0]); r[1] = ref2(x[6:5], f[1]); r[2] = ref2(x[4:3], f[2]);
        e.vld = 4'b0111; e.sm = x[2:0]; e.smv = 1;
      end
      3'd4: begin
        r[1] = ref2(x[8:7], f[1]); r[0] = ref2(x[6:5], f[0]); r[3] = ref2(x[4:3], f[3]);
        e.vld = 4'b1011;
        if (e.dec && x[2:0] != 0) e.ill = 1;
      end
      default: if (e.dec) e.ill = 1;
    endcase
    for (int k = 0; k < 4; k++) begin
      e.vec[k] = r[k][7];
      e.rg[k]  = r[k][6:0];
    end
    e.rq = rq;
    @(negedge clk);
    prefix = p; suffix = s; profile = pr; fp_single = fp; field = f; in_valid = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    sb.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor: random backpressure, in-order compare
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[1] | done;
      #1;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          chk(0, "R11", "unexpected output", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(decoded == e.dec, "R1", "decoded", 32'(decoded), 32'(e.dec));
          chk({mask_kind, mask, ew_dst, ew_src, subvl, mode} == {e.mk, e.mask, e.ewd, e.ews, e.svl, e.mode},
              e.dec ? "R2" : "R10", "subfields",
              32'({mask_kind, mask, ew_dst, ew_src, subvl, mode}),
              32'({e.mk, e.mask, e.ewd, e.ews, e.svl, e.mode}));
          chk(suffix_q == e.sfx, "R11", "suffix", suffix_q, e.sfx);
          chk(ew_bits == e.ewb, "R7", "ew_bits", 32'(ew_bits), 32'(e.ewb));
          chk({src_mask, src_mask_vld, alt_dst} == {e.sm, e.smv, e.alt}, "R6", "masks",
              32'({src_mask, src_mask_vld, alt_dst}), 32'({e.sm, e.smv, e.alt}));
          chk(reg_vld == e.vld, "R5", "slot valid", 32'(reg_vld), 32'(e.vld));
          chk(regs == e.rg, e.rq, "regs", 32'(regs), 32'(e.rg));
          chk(reg_vec == e.vec, e.rq, "vector tags", 32'(reg_vec), 32'(e.vec));
          chk(illegal == e.ill, e.rq, "illegal", 32'(illegal), 32'(e.ill));
        end
      end else if (out_valid) begin
        chk(!in_ready, "R11", "ready while stalled", 32'(in_ready), 0);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0][4:0] f;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R12", "out_valid in reset", 32'(out_valid), 0);
    chk(in_ready, "R12", "in_ready in reset", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R12", "idle after reset", 32'({out_valid, in_ready}), 1);

    // R3: every 3-bit tag against every field
    for (int t = 0; t < 8; t++)
      for (int v = 0; v < 32; v++) begin
        f = {5'd0, 5'(v + 7), 5'(v ^ 31), 5'(v)};
        send(mk_prefix(0, 0, 0, 0, 0, {3'(t), 3'(7 - t), 3'(t ^ 5)}, 0),
             32'(v * 977), 3'd1, 0, f, "R3");
      end
    // R4: every 2-bit tag against every field
    for (int t = 0; t < 4; t++)
      for (int v = 0; v < 32; v++) begin
        f = {5'(v + 3), 5'(v + 7), 5'(v ^ 31), 5'(v)};
        send(mk_prefix(0, 0, 0, 0, 0, {2'(t), 2'(3 - t), 2'(t ^ 1), 2'(t ^ 2), 1'(v)}, 0),
             32'(v), 3'd0, 0, f, "R4");
      end
    f = {5'd17, 5'd9, 5'd30, 5'd5};
    // R5/R6 layouts
    send(mk_prefix(1, 3'd5, 0, 2'd1, 2'd2, 9'b101_011_110, 5'd9), 32'h1111, 3'd2, 0, f, "R5");
    send(mk_prefix(0, 3'd2, 0, 0, 2'd3, 9'b11_10_01_101, 5'd3), 32'h2222, 3'd3, 0, f, "R6");
    send(mk_prefix(0, 0, 0, 0, 0, 9'b01_11_10_000, 0), 32'h3333, 3'd4, 0, f, "R5");
    // R9 reserved
    send(mk_prefix(0, 0, 0, 0, 0, 9'b01_11_10_010, 0), 32'h4444, 3'd4, 0, f, "R9");
    for (int p = 5; p < 8; p++)
      send(mk_prefix(0, 0, 0, 0, 0, 9'h0a5, 0), 32'(p), 3'(p), 0, f, "R9");
    // R7/R8 element widths
    for (int w = 0; w < 4; w++) begin
      send(mk_prefix(0, 0, 2'(w), 2'(3 - w), 0, 0, 0), 32'(w), 3'd1, 1, f, "R8");
      send(mk_prefix(0, 0, 2'(w), 0, 0, 0, 0), 32'(w), 3'd1, 0, f, "R7");
    end
    // R10 non-matching prefixes and all-zero remap
    send(32'h0000_0000, 32'hdead, 3'd0, 1, f, "R10");
    send(mk_prefix(1, 7, 3, 3, 3, 9'h1ff, 31) & ~32'h0100_0000, 32'h1, 3'd1, 1, f, "R10");
    send(mk_prefix(1, 7, 3, 3, 3, 9'h1ff, 31) & ~32'h0040_0000, 32'h2, 3'd0, 1, f, "R10");
    send(mk_prefix(1, 7, 3, 3, 3, 9'h1ff, 31) ^ 32'h0800_0000, 32'h3, 3'd6, 1, f, "R10");
    send(mk_prefix(0, 0, 0, 0, 0, 0, 0), 32'h4, 3'd0, 0, f, "R10");
    // R2 subfield placement
    send(mk_prefix(1, 3'd6, 2'd2, 2'd1, 2'd3, 9'h155, 5'd22), 32'h5, 3'd1, 0, f, "R2");
    send(mk_prefix(0, 3'd1, 2'd1, 2'd2, 2'd1, 9'h0aa, 5'd9), 32'h6, 3'd0, 0, f, "R2");

    repeat (4) @(negedge clk);
    done = 1;
    while (sb.size() != 0 || out_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule